// File: doc/BRIEF.md
# Time-over-threshold transition recorder

This block watches a bank of strip channels, each of which drives two synchronized comparator outputs: a low-threshold bit and a high-threshold bit. It does not look at all channels at once. An 8:1 scan visits one slot of channels per scan period. Channel `c` belongs to group `c / 8` and is examined in slot `c % 8`. A coarse event-time counter advances once every full pass of eight slots.

Whenever a comparator changes level between two visits, the block queues one entry. The entry carries the coarse time, the group, the slot, which comparator changed and in which direction. Rising and falling edges are both kept, so downstream logic can subtract the two times and recover how long a pulse stayed above threshold. That difference is the amplitude measure.

High-threshold edges only count while the channel's low comparator is active. Entries leave through a show-ahead pop port. When the queue is full, new entries are lost and a sticky flag records the loss.

Top module: `tot_recorder`

## Requirements
- R1: A synchronous reset empties the queue (`popValid` low), clears `overflow`, clears every stored comparator level, and restarts the scan at slot 0 and time 0.
- R2: Every channel is examined once per coarse tick, in slot `c % 8`. Its entries carry group `c / 8` and slot `c % 8`. With default parameters the entry layout is: bit 0 = rising (1) or falling (0), bit 1 = high (1) or low (0) comparator, bits 4:2 = slot, bit 5 = group, bits 13:6 = coarse time.
- R3: One coarse tick lasts eight slots of `2*NUM_CH/8 + 1` clocks each. The time field counts ticks and wraps modulo 2^TIME_W.
- R4: Every level change of the low comparator queues one entry, for rising and for falling edges alike. When both edges sit on the same phase of the scan, the difference between their time fields, taken modulo 2^TIME_W, equals the pulse length in ticks.
- R5: A high-comparator change queues an entry only if that channel's low comparator was 1 at the previous visit or is 1 at the current visit. Any other high change is discarded and queues nothing.
- R6: Changes found in the same slot visit are queued one per clock in ascending order of comparator index (2 × group + type, where low = 0 and high = 1). All of them carry the same time field.
- R7: A change that arrives while the queue holds FIFO_DEPTH entries is dropped, even if a pop happens in the same cycle. `overflow` then goes to 1 and stays at 1 until reset.
- R8: While the queue is not empty, `popValid` is high and `popData` shows the oldest entry. Raising `popReq` while `popValid` is high removes that entry at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan and system clock |
| rst | input | 1 | Synchronous reset, active high |
| cmpLow | input | NUM_CH | Low-threshold comparator bits, one per channel |
| cmpHigh | input | NUM_CH | High-threshold comparator bits, one per channel |
| popReq | input | 1 | Remove the oldest entry |
| popValid | output | 1 | Queue holds at least one entry |
| popData | output | TIME_W+GRP_W+5 | Oldest entry: time, group, slot, type, polarity |
| overflow | output | 1 | Sticky flag: an entry was dropped |

## Verification
The assertions assume that comparator levels move slowly compared with the scan. They also assume that `popReq` is raised only while `popValid` is high. Both hold for any front end whose pulses are longer than a coarse tick.

The stimulus changes comparator levels only on falling clock edges, and always an exact whole number of ticks apart. This keeps each pair of edges on one scan phase, so the expected time differences are exact integers. The random pulses always nest the high pulse inside the low pulse, which keeps the gating rule in its normal regime. Separate directed cases place a high pulse with no low pulse around it and drive simultaneous edges in one slot.

// File: rtl/totRec_pkg.sv
package totRec_pkg;
  // Strobes issued by the scan controller to the datapath each clock
  typedef struct packed {
    logic scanLoad;   // first clock of a slot: sample the slot's comparators
    logic slotLast;   // last clock of a slot
    logic tickLast;   // last clock of the last slot: time advances
  } ctrlStrobe_t;
endpackage

// File: rtl/totRec_ctrl.sv
module totRec_ctrl
  import totRec_pkg::*;
#(
  parameter int SCAN_RATIO = 8,
  parameter int SLOT_CYC   = 5,
  parameter int TIME_W     = 8,
  localparam int SLOT_W    = $clog2(SCAN_RATIO),
  localparam int DIV_W     = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output ctrlStrobe_t       strobe,
  output logic [SLOT_W-1:0] slotCnt,
  output logic [TIME_W-1:0] timeCnt
);
  logic [DIV_W-1:0] divCnt;

  always_comb begin
    strobe.scanLoad = (divCnt == '0);
    strobe.slotLast = (divCnt == DIV_W'(SLOT_CYC - 1));
    strobe.tickLast = strobe.slotLast && (slotCnt == SLOT_W'(SCAN_RATIO - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt  <= '0;
      slotCnt <= '0;
      timeCnt <= '0;
    end else begin
      divCnt <= strobe.slotLast ? '0 : divCnt + 1'b1;
      if (strobe.slotLast)
        slotCnt <= strobe.tickLast ? '0 : slotCnt + 1'b1;
      if (strobe.tickLast)
        timeCnt <= timeCnt + 1'b1;
    end
  end

  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.tickLast |=> $stable(timeCnt)); // R3
  AST_TIME_STEP: assert property (@(posedge clk) disable iff (rst)
    strobe.tickLast |=> timeCnt == TIME_W'($past(timeCnt) + 1'b1)); // R3
endmodule

// File: rtl/totRec_datapath.sv
module totRec_datapath
  import totRec_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int SCAN_RATIO = 8,
  parameter int TIME_W     = 8,
  localparam int NUM_GROUPS = NUM_CH / SCAN_RATIO,
  localparam int COMPS      = 2 * NUM_GROUPS,
  localparam int COMP_W     = (COMPS > 1) ? $clog2(COMPS) : 1,
  localparam int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int SLOT_W     = $clog2(SCAN_RATIO),
  localparam int CH_W       = $clog2(NUM_CH),
  localparam int ENTRY_W    = TIME_W + GRP_W + SLOT_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobe_t        strobe,
  input  logic [SLOT_W-1:0]  slotCnt,
  input  logic [TIME_W-1:0]  timeCnt,
  input  logic [NUM_CH-1:0]  cmpLow,
  input  logic [NUM_CH-1:0]  cmpHigh,
  output logic               wrValid,
  output logic [ENTRY_W-1:0] wrEntry
);
  // Two-flop synchronizers
  logic [NUM_CH-1:0] lowMeta, lowSync, highMeta, highSync;
  // Level seen at each comparator's previous visit
  logic [NUM_CH-1:0] prevLow, prevHigh;

  logic [NUM_GROUPS-1:0] lowNow, highNow, lowOld, highOld;
  logic [CH_W-1:0]       chIdx [NUM_GROUPS];
  logic [COMPS-1:0]      evMask, evRise;

  // Pending changes of the current slot, drained lowest index first
  logic [COMPS-1:0]  pending, pendRise;
  logic [TIME_W-1:0] stampTime;
  logic [SLOT_W-1:0] stampSlot;
  logic [COMP_W-1:0] selIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      lowMeta  <= '0;
      lowSync  <= '0;
      highMeta <= '0;
      highSync <= '0;
    end else begin
      lowMeta  <= cmpLow;
      lowSync  <= lowMeta;
      highMeta <= cmpHigh;
      highSync <= highMeta;
    end
  end

  // One 8:1 selector per group
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    assign chIdx[g]   = CH_W'(g * SCAN_RATIO) + CH_W'(slotCnt);
    assign lowNow[g]  = lowSync[chIdx[g]];
    assign highNow[g] = highSync[chIdx[g]];
    assign lowOld[g]  = prevLow[chIdx[g]];
    assign highOld[g] = prevHigh[chIdx[g]];
    // Low edges always count; high edges only inside the low window
    assign evMask[2*g]   = lowNow[g] ^ lowOld[g];
    assign evRise[2*g]   = lowNow[g];
    assign evMask[2*g+1] = (highNow[g] ^ highOld[g]) && (lowNow[g] || lowOld[g]);
    assign evRise[2*g+1] = highNow[g];
  end

  always_comb begin
    selIdx = '0;
    for (int j = COMPS - 1; j >= 0; j--)
      if (pending[j]) selIdx = COMP_W'(j);
  end

  assign wrValid = |pending;
  assign wrEntry = {stampTime, GRP_W'(selIdx >> 1), stampSlot, selIdx[0], pendRise[selIdx]};

  always_ff @(posedge clk) begin
    if (rst) begin
      prevLow   <= '0;
      prevHigh  <= '0;
      pending   <= '0;
      pendRise  <= '0;
      stampTime <= '0;
      stampSlot <= '0;
    end else if (strobe.scanLoad) begin
      pending   <= evMask;
      pendRise  <= evRise;
      stampTime <= timeCnt;
      stampSlot <= slotCnt;
      for (int g = 0; g < NUM_GROUPS; g++) begin
        prevLow[chIdx[g]]  <= lowNow[g];
        prevHigh[chIdx[g]] <= highNow[g];
      end
    end else if (wrValid) begin
      pending[selIdx] <= 1'b0;
    end
  end

  AST_DRAIN_DONE: assert property (@(posedge clk) disable iff (rst)
    strobe.scanLoad |-> pending == '0); // R6
  AST_ONE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (wrValid && !strobe.scanLoad) |=> $countones(pending) == $countones($past(pending)) - 1); // R6
  AST_STAMP_HELD: assert property (@(posedge clk) disable iff (rst)
    !strobe.scanLoad |=> $stable(stampTime) && $stable(stampSlot)); // R6
endmodule

// File: rtl/totRec_fifo.sv
module totRec_fifo #(
  parameter int WIDTH = 14,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrValid,
  input  logic [WIDTH-1:0] wrData,
  input  logic             popReq,
  output logic             popValid,
  output logic [WIDTH-1:0] popData,
  output logic             overflow
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [PTR_W:0]   count;
  logic             full, doPush, doPop;

  assign full     = (count == (PTR_W+1)'(DEPTH));
  assign popValid = (count != '0);
  assign popData  = mem[rdPtr];
  assign doPush   = wrValid && !full;
  assign doPop    = popReq && popValid;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + (PTR_W+1)'(doPush) - (PTR_W+1)'(doPop);
      if (wrValid && full) overflow <= 1'b1;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (wrValid && full && !popReq) |=> full && overflow); // R7
  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
    (popReq && popValid && !wrValid) |=> count == $past(count) - 1'b1); // R8
endmodule

// File: rtl/tot_recorder.sv
module tot_recorder
  import totRec_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int SCAN_RATIO = 8,
  parameter int TIME_W     = 8,
  parameter int FIFO_DEPTH = 8,
  localparam int NUM_GROUPS = NUM_CH / SCAN_RATIO,
  localparam int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int SLOT_W     = $clog2(SCAN_RATIO),
  localparam int SLOT_CYC   = 2 * NUM_GROUPS + 1,
  localparam int ENTRY_W    = TIME_W + GRP_W + SLOT_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CH-1:0]  cmpLow,
  input  logic [NUM_CH-1:0]  cmpHigh,
  input  logic               popReq,
  output logic               popValid,
  output logic [ENTRY_W-1:0] popData,
  output logic               overflow
);
  ctrlStrobe_t        strobe;
  logic [SLOT_W-1:0]  slotCnt;
  logic [TIME_W-1:0]  timeCnt;
  logic               wrValid;
  logic [ENTRY_W-1:0] wrEntry;

  totRec_ctrl #(.SCAN_RATIO(SCAN_RATIO), .SLOT_CYC(SLOT_CYC), .TIME_W(TIME_W)) u_ctrl (
    .clk(clk), .rst(rst), .strobe(strobe), .slotCnt(slotCnt), .timeCnt(timeCnt));

  totRec_datapath #(.NUM_CH(NUM_CH), .SCAN_RATIO(SCAN_RATIO), .TIME_W(TIME_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .slotCnt(slotCnt), .timeCnt(timeCnt),
    .cmpLow(cmpLow), .cmpHigh(cmpHigh), .wrValid(wrValid), .wrEntry(wrEntry));

  totRec_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wrValid(wrValid), .wrData(wrEntry), .popReq(popReq),
    .popValid(popValid), .popData(popData), .overflow(overflow));
endmodule

// File: tb/tot_recorder_bench.sv
module tot_recorder_bench;
  localparam int NUM_CH = 16;
  localparam int TIME_W = 8;
  localparam int ENTRY_W = 14;
  localparam int TICK_CYC = 8 * 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_CH-1:0] cmpLow = '0, cmpHigh = '0;
  logic popReq = 1'b0;
  logic popValid, overflow;
  logic [ENTRY_W-1:0] popData;

  int nRun = 0, nFail = 0;
  bit finished = 1'b0;
  bit collectOn = 1'b1;
  logic [ENTRY_W-1:0] ent [512];
  int nEnt = 0;

  always #4 clk = ~clk;

  tot_recorder u_tot_recorder (.clk(clk), .rst(rst), .cmpLow(cmpLow), .cmpHigh(cmpHigh),
    .popReq(popReq), .popValid(popValid), .popData(popData), .overflow(overflow));

  // Draining process: one pop per clock while enabled
  initial forever begin
    @(negedge clk);
    if (collectOn && popValid) begin
      if (nEnt < 512) ent[nEnt] = popData;
      nEnt++;
      popReq = 1'b1;
    end else popReq = 1'b0;
  end

  function automatic int fTime(logic [ENTRY_W-1:0] e); return int'(e[13:6]); endfunction
  function automatic int fGrp(logic [ENTRY_W-1:0] e);  return int'(e[5]);    endfunction
  function automatic int fSlot(logic [ENTRY_W-1:0] e); return int'(e[4:2]);  endfunction
  function automatic int fHigh(logic [ENTRY_W-1:0] e); return int'(e[1]);    endfunction
  function automatic int fRise(logic [ENTRY_W-1:0] e); return int'(e[0]);    endfunction
  function automatic int tDiff(int a, int b); return (b - a + 256) % 256; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  task automatic waitTicks(input int n);
    repeat (n * TICK_CYC) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
  endtask

  // One nested pulse: low for lenL ticks, high from +a for lenH ticks
  task automatic pulseTrial(input int ch, input int lenL, input int a, input int lenH);
    int expT[4], expH[4], expR[4];
    nEnt = 0;
    @(negedge clk);
    for (int k = 0; k <= lenL; k++) begin
      if (k == 0)         cmpLow[ch] = 1'b1;
      if (k == a)         cmpHigh[ch] = 1'b1;
      if (k == a + lenH)  cmpHigh[ch] = 1'b0;
      if (k == lenL)      cmpLow[ch] = 1'b0;
      if (k < lenL) waitTicks(1);
    end
    waitTicks(2);
    // expected order: by time, then low before high
    expT = '{0, a, a + lenH, lenL}; expH = '{0, 1, 1, 0}; expR = '{1, 1, 0, 0};
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3 - i; j++)
        if (expT[j] > expT[j+1] || (expT[j] == expT[j+1] && expH[j] > expH[j+1])) begin
          int t;
          t = expT[j]; expT[j] = expT[j+1]; expT[j+1] = t;
          t = expH[j]; expH[j] = expH[j+1]; expH[j+1] = t;
          t = expR[j]; expR[j] = expR[j+1]; expR[j+1] = t;
        end
    chk(nEnt == 4, "R4 entry count", nEnt, 4);
    if (nEnt == 4)
      for (int i = 0; i < 4; i++) begin
        chk(fSlot(ent[i]) == ch % 8 && fGrp(ent[i]) == ch / 8, "R2 slot/group",
            fSlot(ent[i]) + 8 * fGrp(ent[i]), ch);
        chk(tDiff(fTime(ent[0]), fTime(ent[i])) == expT[i], "R4 R5 edge time offset",
            tDiff(fTime(ent[0]), fTime(ent[i])), expT[i]);
        chk(fHigh(ent[i]) == expH[i] && fRise(ent[i]) == expR[i], "R6 type/polarity",
            2 * fHigh(ent[i]) + fRise(ent[i]), 2 * expH[i] + expR[i]);
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0071));
    doReset();
    // R1 reset state
    @(negedge clk);
    chk(popValid == 1'b0, "R1 empty after reset", int'(popValid), 0);
    chk(overflow == 1'b0, "R1 overflow clear", int'(overflow), 0);

    // R4 R3 wrap: low pulse of 300 ticks crosses the 256-tick wrap
    nEnt = 0;
    cmpLow[5] = 1'b1; waitTicks(300); cmpLow[5] = 1'b0; waitTicks(2);
    chk(nEnt == 2, "R4 wrap entry count", nEnt, 2);
    if (nEnt == 2)
      chk(tDiff(fTime(ent[0]), fTime(ent[1])) == 44, "R3 wrapped width",
          tDiff(fTime(ent[0]), fTime(ent[1])), 44);

    // R5 high pulse without low: discarded
    nEnt = 0;
    cmpHigh[3] = 1'b1; waitTicks(3); cmpHigh[3] = 1'b0; waitTicks(2);
    chk(nEnt == 0, "R5 ungated high discarded", nEnt, 0);
    // R5 low pulse around a high change whose edges fall outside the window
    nEnt = 0;
    cmpHigh[3] = 1'b1; waitTicks(2); cmpLow[3] = 1'b1; waitTicks(3);
    cmpLow[3] = 1'b0; waitTicks(2); cmpHigh[3] = 1'b0; waitTicks(2);
    chk(nEnt == 2, "R5 only low edges recorded", nEnt, 2);
    if (nEnt == 2)
      chk(fHigh(ent[0]) == 0 && fHigh(ent[1]) == 0, "R5 no high entry",
          fHigh(ent[0]) + fHigh(ent[1]), 0);

    // R6 simultaneous edges in slot 2, groups 0 and 1
    nEnt = 0;
    cmpLow[2] = 1'b1; cmpHigh[2] = 1'b1; cmpLow[10] = 1'b1; cmpHigh[10] = 1'b1;
    waitTicks(2);
    cmpLow[2] = 1'b0; cmpHigh[2] = 1'b0; cmpLow[10] = 1'b0; cmpHigh[10] = 1'b0;
    waitTicks(2);
    chk(nEnt == 8, "R6 simultaneous count", nEnt, 8);
    if (nEnt == 8)
      for (int i = 0; i < 8; i++) begin
        int expCode;
        expCode = 4 * ((i % 4) / 2) + 2 * (i % 2) + ((i < 4) ? 1 : 0);
        chk(4 * fGrp(ent[i]) + 2 * fHigh(ent[i]) + fRise(ent[i]) == expCode,
            "R6 ascending order", 4 * fGrp(ent[i]) + 2 * fHigh(ent[i]) + fRise(ent[i]), expCode);
        chk(fTime(ent[i]) == fTime(ent[(i / 4) * 4]) && fSlot(ent[i]) == 2, "R6 shared stamp",
            fTime(ent[i]), fTime(ent[(i / 4) * 4]));
      end

    // Random nested pulses
    for (int t = 0; t < 12; t++) begin
      int ch, lenL, a, lenH;
      ch = int'($urandom_range(0, NUM_CH - 1));
      lenL = int'($urandom_range(2, 12));
      a = int'($urandom_range(0, lenL - 2));
      lenH = int'($urandom_range(1, lenL - a));
      pulseTrial(ch, lenL, a, lenH);
    end
    pulseTrial(7, 4, 0, 4);  // corner: high shares both low edges

    // R7 overflow: 10 edges with the queue not drained
    collectOn = 1'b0;
    @(negedge clk); popReq = 1'b0;
    nEnt = 0;
    for (int c = 0; c < 5; c++) cmpLow[c] = 1'b1;
    waitTicks(2);
    for (int c = 0; c < 5; c++) cmpLow[c] = 1'b0;
    waitTicks(2);
    chk(overflow == 1'b1, "R7 overflow set", int'(overflow), 1);
    chk(popValid == 1'b1, "R8 valid while full", int'(popValid), 1);
    collectOn = 1'b1;
    waitTicks(1);
    chk(nEnt == 8, "R7 kept entries", nEnt, 8);
    chk(overflow == 1'b1, "R7 overflow sticky", int'(overflow), 1);
    chk(popValid == 1'b0, "R8 drained", int'(popValid), 0);
    doReset();
    @(negedge clk);
    chk(overflow == 1'b0, "R1 R7 reset clears overflow", int'(overflow), 0);
    summary();
  end
endmodule